// File: doc/BRIEF.md
# Supply and Watchdog Reset Supervisor

This block generates a system reset for the logic around it under two conditions. The first is a low supply. A digitized supply level is compared against two thresholds that form a hysteresis band. Reset is asserted as soon as the level falls under the lower threshold. Once the level climbs above the upper threshold, reset is held for a power-up hold interval and then released. The second condition is a stalled system. Software or a state machine is expected to toggle a clear line. If no falling edge shows up on that line within the monitoring interval, the block emits a reset pulse of fixed width. It then resumes monitoring, so a system that stays stalled receives a regular train of pulses.

All three intervals come from one time base: a free-running prescaler that divides the system clock into ticks. The hold interval, the monitoring interval and the pulse width keep a ratio of 50:5:1, and a single parameter scales all three. A disable input turns the watchdog off, which leaves the block working as a supply detector only. The reset is available in both polarities.

Top module: `rst_supervisor`

## Requirements
- R1: When the supply code is strictly below `LO_TH`, `sys_rst_o` is 1 at the clock edge that samples it. After the asynchronous reset `rst_ni`, `sys_rst_o` is 1.
- R2: While reset is asserted, a supply code in the range `LO_TH`..`HI_TH` (both ends included) never releases it. While reset is released, a code in that same range never asserts it.
- R3: Once the code is strictly above `HI_TH`, reset stays asserted for `HOLD_T = 50*PW_TICKS` ticks. A tick is `TICK_DIV` clock cycles. Reset is then released.
- R4: If the code falls below `LO_TH` during the power-up hold, the hold is abandoned. The next rise above `HI_TH` starts a complete new hold.
- R5: With the watchdog enabled and no falling edges on `wd_clr_i`, a reset pulse begins `MON_T = 5*PW_TICKS` ticks after monitoring starts. The low gap between two successive pulses is exactly `MON_T*TICK_DIV` cycles.
- R6: Each watchdog reset pulse lasts exactly `PW_TICKS*TICK_DIV` cycles.
- R7: A falling edge (1 to 0) on `wd_clr_i` restarts the monitoring interval after a two-flop synchronizer. The effective edge acts three clock edges after the pin falls. Clears spaced `(MON_T-1)` ticks apart or closer never let a pulse out.
- R8: Falling edges on `wd_clr_i` during a watchdog pulse neither shorten the pulse nor restart the following interval.
- R9: While `wd_off_i` is 1, no watchdog pulse is produced. When it returns to 0, monitoring restarts from zero.
- R10: While reset is asserted for supply reasons, the watchdog count stays at zero. The first pulse after a supply release starts exactly `MON_T*TICK_DIV` cycles after the release.
- R11: `sys_rst_no` is always the exact complement of `sys_rst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block itself |
| supply_code_i | input | VW | Unsigned digitized supply level |
| wd_clr_i | input | 1 | Watchdog clear line, asynchronous; falling edges clear |
| wd_off_i | input | 1 | 1 disables the watchdog |
| sys_rst_o | output | 1 | System reset, active high |
| sys_rst_no | output | 1 | System reset, active low |

## Verification
The supply side is driven in three ways: random codes inside the hysteresis band, random codes below the lower threshold, and clean rises. These separate a correct two-threshold detector from a single-threshold one, and a restarted hold from one that resumes. On the watchdog side, clear trains with random spacing up to one tick short of expiry are set against a silent clear line. This shows whether the interval restarts on falling edges and how long it lasts. Clears toggled inside a pulse, together with enabling and disabling the watchdog, separate an ignored clear from an honoured one and a frozen counter from a running one.

// File: rtl/sup_pkg.sv
`timescale 1ns/1ps
package sup_pkg;
    typedef enum logic [1:0] {BO_LOW, BO_HOLD, BO_OK} bo_state_e;
    typedef enum logic {WD_WATCH, WD_PULSE} wd_state_e;
    localparam int unsigned SCALE_MON  = 5;
    localparam int unsigned SCALE_HOLD = 50;
endpackage

// File: rtl/sup_clr_sync.sv
`timescale 1ns/1ps
module sup_clr_sync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    output logic fall_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d.s1 = clr_i;
        d.s2 = q.s1;
        d.s3 = q.s2;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{s1: 1'b1, s2: 1'b1, s3: 1'b1};
        else         q <= d;
    end

    assign fall_o = q.s3 & ~q.s2;

    AST_FALL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |=> !fall_o); // R7
endmodule

// File: rtl/sup_tick.sv
`timescale 1ns/1ps
module sup_tick #(
    parameter int unsigned DIV = 1000
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (cnt_q == CW'(DIV - 1)) cnt_d = '0;
        else                       cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign tick_o = (cnt_q == CW'(DIV - 1));

    AST_TICK_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/sup_brownout.sv
`timescale 1ns/1ps
module sup_brownout
    import sup_pkg::*;
#(
    parameter int unsigned VW     = 8,
    parameter int unsigned LO_TH  = 200,
    parameter int unsigned HI_TH  = 205,
    parameter int unsigned HOLD_T = 5000
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic [VW-1:0] level_i,
    output logic          ok_o
);
    localparam int unsigned HW = $clog2(HOLD_T + 1);

    typedef struct packed {
        bo_state_e     st;
        logic [HW-1:0] cnt;
    } bo_regs_t;

    bo_regs_t q, d;
    logic below, above;

    assign below = (level_i < VW'(LO_TH));
    assign above = (level_i > VW'(HI_TH));

    always_comb begin
        d = q;
        unique case (q.st)
            BO_LOW: begin
                if (above) begin
                    d.st  = BO_HOLD;
                    d.cnt = '0;
                end
            end
            BO_HOLD: begin
                if (below) begin
                    d.st = BO_LOW;
                end else if (tick_i) begin
                    if (q.cnt == HW'(HOLD_T - 1)) begin
                        d.st  = BO_OK;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            BO_OK: begin
                if (below) d.st = BO_LOW;
            end
            default: d.st = BO_LOW;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{st: BO_LOW, cnt: '0};
        else         q <= d;
    end

    assign ok_o = (q.st == BO_OK);

    AST_LOW_TRIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        below |=> (q.st == BO_LOW)); // R1
    AST_BAND_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == BO_LOW && !above) |=> (q.st == BO_LOW)); // R2
    AST_HOLD_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ok_o) |-> ($past(q.cnt) == HW'(HOLD_T - 1))); // R3
endmodule

// File: rtl/rst_supervisor.sv
`timescale 1ns/1ps
module rst_supervisor
    import sup_pkg::*;
#(
    parameter int unsigned VW       = 8,
    parameter int unsigned LO_TH    = 200,
    parameter int unsigned HI_TH    = 205,
    parameter int unsigned TICK_DIV = 1000,
    parameter int unsigned PW_TICKS = 100
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [VW-1:0] supply_code_i,
    input  logic          wd_clr_i,
    input  logic          wd_off_i,
    output logic          sys_rst_o,
    output logic          sys_rst_no
);
    localparam int unsigned MON_T  = SCALE_MON * PW_TICKS;
    localparam int unsigned HOLD_T = SCALE_HOLD * PW_TICKS;
    localparam int unsigned WW     = $clog2(MON_T + 1);

    typedef struct packed {
        wd_state_e     st;
        logic [WW-1:0] cnt;
    } wd_regs_t;

    logic tick, clr_fall, supply_ok;
    wd_regs_t q, d;

    sup_tick #(.DIV(TICK_DIV)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick)
    );

    sup_clr_sync u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (wd_clr_i),
        .fall_o (clr_fall)
    );

    sup_brownout #(
        .VW     (VW),
        .LO_TH  (LO_TH),
        .HI_TH  (HI_TH),
        .HOLD_T (HOLD_T)
    ) u_bo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick),
        .level_i (supply_code_i),
        .ok_o    (supply_ok)
    );

    always_comb begin
        d = q;
        if (!supply_ok || wd_off_i) begin
            d.st  = WD_WATCH;
            d.cnt = '0;
        end else begin
            unique case (q.st)
                WD_WATCH: begin
                    if (clr_fall) begin
                        d.cnt = '0;
                    end else if (tick) begin
                        if (q.cnt == WW'(MON_T - 1)) begin
                            d.st  = WD_PULSE;
                            d.cnt = '0;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                WD_PULSE: begin
                    if (tick) begin
                        if (q.cnt == WW'(PW_TICKS - 1)) begin
                            d.st  = WD_WATCH;
                            d.cnt = '0;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                default: d.st = WD_WATCH;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{st: WD_WATCH, cnt: '0};
        else         q <= d;
    end

    assign sys_rst_o  = !supply_ok || (q.st == WD_PULSE);
    assign sys_rst_no = ~sys_rst_o;

    AST_WATCH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == WD_WATCH) |-> (q.cnt < WW'(MON_T))); // R5
    AST_PULSE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == WD_PULSE) |-> (q.cnt < WW'(PW_TICKS))); // R6
    AST_OFF_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wd_off_i |=> (q.st == WD_WATCH && q.cnt == '0)); // R9
    AST_SUPPLY_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !supply_ok |=> (q.st == WD_WATCH && q.cnt == '0)); // R10
endmodule

// File: tb/tb_rst_supervisor.sv
`timescale 1ns/1ps
module tb_rst_supervisor;
    localparam int VW  = 8;
    localparam int LO  = 200;
    localparam int HI  = 205;
    localparam int D   = 4;
    localparam int PW  = 4;
    localparam int MON = 5 * PW;
    localparam int HLD = 50 * PW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [VW-1:0] vcode = '0;
    logic          clr = 1'b1;
    logic          off = 1'b0;
    logic          rst_o, rst_no;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    rst_supervisor #(
        .VW(VW), .LO_TH(LO), .HI_TH(HI), .TICK_DIV(D), .PW_TICKS(PW)
    ) dut (
        .clk_i(clk), .rst_ni(rst_n), .supply_code_i(vcode),
        .wd_clr_i(clr), .wd_off_i(off),
        .sys_rst_o(rst_o), .sys_rst_no(rst_no)
    );

    always #10 clk = ~clk;

    function automatic int f_pulse();  return PW * D;  endfunction
    function automatic int f_gap();    return MON * D; endfunction
    function automatic int f_hold_lo(); return (HLD - 1) * D; endfunction
    function automatic int f_hold_hi(); return HLD * D + 2; endfunction
    function automatic int rnd(input int lo, input int hi);
        return lo + int'($urandom % (hi - lo + 1));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic count_while(input logic lvl, output int n);
        n = 0;
        while (rst_o == lvl && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic expect_steady(input logic lvl, input int n, input string req);
        int errs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_o !== lvl) errs++;
        end
        chk(errs == 0, req, errs, 0);
    endtask

    // R11: polarity complement at every sample point
    always @(negedge clk) begin
        if (rst_n && !done && (rst_no !== ~rst_o))
            chk(1'b0, "R11 complement", int'(rst_no), int'(~rst_o));
    end

    initial begin
        int n;
        void'($urandom(32'd2024));
        step(3);
        chk(rst_o === 1'b1 && rst_no === 1'b0, "R1 reset state", int'(rst_o), 1);
        rst_n = 1'b1;
        step(2);
        chk(rst_o === 1'b1, "R1 low code after reset", int'(rst_o), 1);

        // R2: random codes inside the band never release
        begin
            int errs = 0;
            for (int i = 0; i < 20; i++) begin
                vcode = VW'(rnd(LO, HI));
                step(10);
                if (rst_o !== 1'b1) errs++;
            end
            chk(errs == 0, "R2 band holds reset", errs, 0);
        end
        vcode = VW'(HI);
        expect_steady(1'b1, 40, "R2 code equal to HI_TH");

        // R4: dip during hold restarts it
        vcode = 8'd230;
        expect_steady(1'b1, 400, "R3 reset during hold");
        vcode = VW'(rnd(0, LO - 1));
        step(1);
        chk(rst_o === 1'b1, "R4 dip during hold", int'(rst_o), 1);
        step(2);
        vcode = 8'd230;
        count_while(1'b1, n);
        chk(n >= f_hold_lo() && n <= f_hold_hi(), "R4 full hold after dip", n, HLD * D);
        chk(n >= f_hold_lo() && n <= f_hold_hi(), "R3 hold length", n, HLD * D);

        // R10 / R6 / R5: free-running pulse train
        count_while(1'b0, n);
        chk(n == f_gap(), "R10 first pulse after release", n, f_gap());
        count_while(1'b1, n);
        chk(n == f_pulse(), "R6 pulse width", n, f_pulse());
        count_while(1'b0, n);
        chk(n == f_gap(), "R5 gap between pulses", n, f_gap());
        count_while(1'b1, n);
        chk(n == f_pulse(), "R6 second pulse width", n, f_pulse());

        // R7: random clear trains, ending one tick short of expiry
        begin
            int errs = 0;
            for (int i = 0; i < 14; i++) begin
                int p;
                p = (i >= 11) ? (MON - 1) * D : rnd(8, (MON - 1) * D);
                clr = 1'b0;
                step(3);
                if (rst_o !== 1'b0) errs++;
                clr = 1'b1;
                for (int k = 3; k < p; k++) begin
                    @(negedge clk);
                    if (rst_o !== 1'b0) errs++;
                end
            end
            chk(errs == 0, "R7 clears keep reset off", errs, 0);
        end
        // last fall was (MON-1)*D cycles ago
        count_while(1'b0, n);
        n = n + (MON - 1) * D;
        chk(n >= (MON - 1) * D + 2 && n <= MON * D + 4, "R7 expiry after last clear", n, MON * D + 3);

        // R8: clears toggled inside a pulse are ignored
        n = 0;
        while (rst_o == 1'b1 && n < 5000) begin
            clr = (n < 12) ? n[1] : 1'b1;
            @(negedge clk);
            n++;
        end
        clr = 1'b1;
        chk(n == f_pulse(), "R8 pulse width with clears", n, f_pulse());
        count_while(1'b0, n);
        chk(n == f_gap(), "R8 gap not restarted", n, f_gap());
        count_while(1'b1, n);

        // R9: watchdog disabled
        off = 1'b1;
        begin
            int errs = 0;
            for (int i = 0; i < 3 * MON * D / 10; i++) begin
                vcode = VW'(rnd(LO, 255));
                step(10);
                if (rst_o !== 1'b0) errs++;
            end
            chk(errs == 0, "R9 no pulses when off", errs, 0);
            chk(errs == 0, "R2 band keeps release", errs, 0);
        end
        vcode = VW'(rnd(0, LO - 1));
        step(1);
        chk(rst_o === 1'b1, "R1 low code trips at once", int'(rst_o), 1);
        step(5);
        vcode = 8'd240;
        count_while(1'b1, n);
        chk(n >= f_hold_lo() && n <= f_hold_hi(), "R3 hold with watchdog off", n, HLD * D);
        expect_steady(1'b0, 3 * MON * D, "R9 silent after hold");
        off = 1'b0;
        count_while(1'b0, n);
        chk(n >= (MON - 1) * D + 1 && n <= MON * D + 1, "R9 restart on enable", n, MON * D);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(150000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule